// File: doc/BRIEF.md
# SLIP Response Frame Transmitter

This block assembles the reply that a serial bootloader returns after each request and streams it, one byte at a time, toward a UART transmitter over a valid/ready handshake. A single-cycle start request captures three things: the command code being answered, a 32-bit result word and a pass/fail flag. A failure also supplies an error code. The block then emits a fixed ten-byte packet inside a SLIP frame. The packet is laid out as follows:

- A direction marker.
- The echoed command.
- A little-endian body length of two.
- The little-endian result word.
- A body of two bytes: the status, then the most recent error code.

Every payload byte equal to the frame delimiter or to the escape byte is replaced on the fly by a two-byte escape sequence. The error code is kept in a sticky register that only a failure overwrites. A run of successful replies therefore keeps reporting the last failure. The block stays busy for the whole frame and ignores new start requests until the closing delimiter has been accepted.

Top module: `slip_resp_tx`

## Requirements
- R1: After reset, outValid and busy are 0, and the sticky error register reads 0 (a success reply sent right after reset carries error byte 0x00).
- R2: Each frame starts with one 0xC0 and ends with one 0xC0, and no 0xC0 appears on outData between them.
- R3: Payload byte 0 is 0x01, and payload byte 1 is the cmdCode captured with the accepted start.
- R4: Payload bytes 2 and 3 are 0x02 and 0x00 (body length 2, low byte first).
- R5: Payload bytes 4 to 7 are valueWord[7:0], [15:8], [23:16] and [31:24], in that order.
- R6: Payload byte 8 is 0x01 when failFlag was 1 at the accepted start, and 0x00 otherwise.
- R7: Payload byte 9 is the sticky error register. An accepted start with failFlag=1 loads errCode into it before the frame is built. An accepted start with failFlag=0 leaves it unchanged.
- R8: A payload byte 0xC0 goes out as 0xDB then 0xDC, and a payload byte 0xDB goes out as 0xDB then 0xDD. All other payload bytes go out unchanged.
- R9: While outValid is 1 and outReady is 0, outData and outValid hold their values, so no byte is lost or repeated under backpressure.
- R10: A startPulse seen while busy is 0 is accepted: from the next cycle, busy and outValid are 1 until the closing 0xC0 is accepted, and then both return to 0. A startPulse seen while busy is 1 has no effect on the frame in progress or on the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request to send one reply frame |
| cmdCode | input | 8 | Command code to echo |
| valueWord | input | 32 | Result word placed in the header |
| failFlag | input | 1 | 1 reports a failure |
| errCode | input | 8 | Error code, loaded only on failure |
| outData | output | 8 | Framed byte toward the UART |
| outValid | output | 1 | outData holds a byte |
| outReady | input | 1 | UART accepts the byte this cycle |
| busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with its default four-byte value word. That places the header, the stuffed body and both delimiters exactly as a UART consumer sees them. Command codes, value words and error codes are chosen so that delimiter and escape bytes land in the header, in the value word and in the sticky error byte. Each escape path is therefore reached at several payload positions, including the last byte before the closing delimiter. A pseudo-random ready pattern places stalls on lead bytes, substitute bytes and delimiters. Start requests are also held high during whole frames, which exercises the ignore path both with and without a pending failure code.

// File: rtl/slip_resp_pkg.sv
package slip_resp_pkg;

  localparam logic [7:0] FRAME_END = 8'hC0;
  localparam logic [7:0] ESC_LEAD  = 8'hDB;
  localparam logic [7:0] ESC_END   = 8'hDC;
  localparam logic [7:0] ESC_ESC   = 8'hDD;
  localparam logic [7:0] RESP_DIR  = 8'h01;
  localparam logic [15:0] RESP_BODY_LEN = 16'd2;
  localparam int HDR_FIXED = 4;   // direction, command, two length bytes

  typedef enum logic [1:0] {
    OUT_DELIM,
    OUT_LEAD,
    OUT_RAW,
    OUT_SUB
  } outSel_e;

  typedef struct packed {
    logic    load;
    logic    incIdx;
    outSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/slip_resp_bytesel.sv
module slip_resp_bytesel
  import slip_resp_pkg::*;
#(
  parameter int VALUE_BYTES = 4,
  parameter int IDX_W       = 4
) (
  input  logic [IDX_W-1:0]         idx,
  input  logic [7:0]               cmdReg,
  input  logic [8*VALUE_BYTES-1:0] valueReg,
  input  logic                     statusReg,
  input  logic [7:0]               errReg,
  output logic [7:0]               curByte
);
  localparam int STATUS_POS = HDR_FIXED + VALUE_BYTES;

  logic [7:0] valueByte;

  always_comb begin
    valueByte = 8'h00;
    for (int k = 0; k < VALUE_BYTES; k++) begin
      if (idx == IDX_W'(HDR_FIXED + k)) valueByte = valueReg[8*k +: 8];
    end
  end

  always_comb begin
    if (idx == IDX_W'(0))               curByte = RESP_DIR;
    else if (idx == IDX_W'(1))          curByte = cmdReg;
    else if (idx == IDX_W'(2))          curByte = RESP_BODY_LEN[7:0];
    else if (idx == IDX_W'(3))          curByte = RESP_BODY_LEN[15:8];
    else if (idx < IDX_W'(STATUS_POS))  curByte = valueByte;
    else if (idx == IDX_W'(STATUS_POS)) curByte = {7'd0, statusReg};
    else                                curByte = errReg;
  end
endmodule

// File: rtl/slip_resp_dp.sv
module slip_resp_dp
  import slip_resp_pkg::*;
#(
  parameter int VALUE_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [7:0]               cmdIn,
  input  logic [8*VALUE_BYTES-1:0] valueIn,
  input  logic                     failIn,
  input  logic [7:0]               errIn,
  output logic [7:0]               outData,
  output logic                     isSpecial,
  output logic                     isLast,
  output logic [7:0]               lastErr
);
  localparam int PAY_LEN = HDR_FIXED + VALUE_BYTES + 2;
  localparam int IDX_W   = $clog2(PAY_LEN);

  logic [IDX_W-1:0]         idx;
  logic [7:0]               cmdReg;
  logic [8*VALUE_BYTES-1:0] valueReg;
  logic                     statusReg;
  logic [7:0]               errReg;
  logic [7:0]               curByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx       <= '0;
      cmdReg    <= '0;
      valueReg  <= '0;
      statusReg <= 1'b0;
      errReg    <= '0;
    end else begin
      if (strobe.load) begin
        idx       <= '0;
        cmdReg    <= cmdIn;
        valueReg  <= valueIn;
        statusReg <= failIn;
        if (failIn) errReg <= errIn;
      end else if (strobe.incIdx) begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  slip_resp_bytesel #(
    .VALUE_BYTES(VALUE_BYTES),
    .IDX_W      (IDX_W)
  ) u_sel (
    .idx      (idx),
    .cmdReg   (cmdReg),
    .valueReg (valueReg),
    .statusReg(statusReg),
    .errReg   (errReg),
    .curByte  (curByte)
  );

  assign isSpecial = (curByte == FRAME_END) || (curByte == ESC_LEAD);
  assign isLast    = (idx == IDX_W'(PAY_LEN - 1));
  assign lastErr   = errReg;

  always_comb begin
    unique case (strobe.sel)
      OUT_DELIM: outData = FRAME_END;
      OUT_LEAD:  outData = ESC_LEAD;
      OUT_RAW:   outData = curByte;
      OUT_SUB:   outData = (curByte == FRAME_END) ? ESC_END : ESC_ESC;
      default:   outData = FRAME_END;
    endcase
  end
endmodule

// File: rtl/slip_resp_ctrl.sv
module slip_resp_ctrl
  import slip_resp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        outReady,
  input  logic        isSpecial,
  input  logic        isLast,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        busy
);
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_BODY,
    ST_SUBST,
    ST_CLOSE
  } txState_e;

  txState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    strobe.load   = 1'b0;
    strobe.incIdx = 1'b0;
    strobe.sel    = OUT_DELIM;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.load = 1'b1;
          nextState   = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (outReady) nextState = ST_BODY;
      end
      ST_BODY: begin
        strobe.sel = isSpecial ? OUT_LEAD : OUT_RAW;
        if (outReady) begin
          if (isSpecial)   nextState = ST_SUBST;
          else if (isLast) nextState = ST_CLOSE;
          else             strobe.incIdx = 1'b1;
        end
      end
      ST_SUBST: begin
        strobe.sel = OUT_SUB;
        if (outReady) begin
          if (isLast) nextState = ST_CLOSE;
          else begin
            strobe.incIdx = 1'b1;
            nextState     = ST_BODY;
          end
        end
      end
      ST_CLOSE: begin
        if (outReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign outValid = busy;
endmodule

// File: rtl/slip_resp_tx.sv
module slip_resp_tx
  import slip_resp_pkg::*;
#(
  parameter int VALUE_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startPulse,
  input  logic [7:0]               cmdCode,
  input  logic [8*VALUE_BYTES-1:0] valueWord,
  input  logic                     failFlag,
  input  logic [7:0]               errCode,
  output logic [7:0]               outData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     busy
);
  ctrlStrobe_t strobe;
  logic        isSpecial;
  logic        isLast;
  logic [7:0]  lastErr;

  slip_resp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .outReady  (outReady),
    .isSpecial (isSpecial),
    .isLast    (isLast),
    .strobe    (strobe),
    .outValid  (outValid),
    .busy      (busy)
  );

  slip_resp_dp #(.VALUE_BYTES(VALUE_BYTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdIn    (cmdCode),
    .valueIn  (valueWord),
    .failIn   (failFlag),
    .errIn    (errCode),
    .outData  (outData),
    .isSpecial(isSpecial),
    .isLast   (isLast),
    .lastErr  (lastErr)
  );
endmodule

// File: rtl/slip_resp_chk.sv
module slip_resp_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       failFlag,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       busy,
  input logic [7:0] lastErr
);
  // R9: a stalled byte stays on the bus unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8: an accepted escape lead is followed by a valid substitute byte
  p_escape_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outData == 8'hDB) |=>
      (outValid && (outData == 8'hDC || outData == 8'hDD)));

  // R10: an accepted start makes the block busy on the next cycle
  p_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy) |=> busy);

  // R2: a frame opens with the delimiter
  p_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (outValid && outData == 8'hC0));

  // R7: the error register only changes on an accepted failure
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && !busy && failFlag) |=> $stable(lastErr));
endmodule

bind slip_resp_tx slip_resp_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .failFlag  (failFlag),
  .outData   (outData),
  .outValid  (outValid),
  .outReady  (outReady),
  .busy      (busy),
  .lastErr   (lastErr)
);

// File: tb/tb_slip_resp_tx.sv
module tb_slip_resp_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [7:0]  cmdCode = 8'h00;
  logic [31:0] valueWord = 32'h0;
  logic        failFlag = 1'b0;
  logic [7:0]  errCode = 8'h00;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        busy;

  int errors = 0;
  int checks = 0;
  int cycleCount = 0;

  byte unsigned expQ[$];
  string        tagQ[$];
  bit           modelBusy = 0;
  byte unsigned modelErr = 0;
  bit           prevStall = 0;
  int           readyMode = 0;
  logic [7:0]   lfsr = 8'hA5;

  always #10 clk = ~clk;

  slip_resp_tx dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmdCode(cmdCode),
    .valueWord(valueWord), .failFlag(failFlag), .errCode(errCode),
    .outData(outData), .outValid(outValid), .outReady(outReady), .busy(busy)
  );

  task automatic pushPay(byte unsigned b, string t);
    if (b == 8'hC0 || b == 8'hDB) begin
      expQ.push_back(8'hDB);
      tagQ.push_back({"R8/", t});
      expQ.push_back(b == 8'hC0 ? 8'hDC : 8'hDD);
      tagQ.push_back({"R8/", t});
    end else begin
      expQ.push_back(b);
      tagQ.push_back(t);
    end
  endtask

  task automatic buildFrame(byte unsigned c, logic [31:0] v, bit f);
    expQ.push_back(8'hC0); tagQ.push_back("R2");
    pushPay(8'h01, "R3");
    pushPay(c, "R3");
    pushPay(8'h02, "R4");
    pushPay(8'h00, "R4");
    for (int k = 0; k < 4; k++) pushPay(v[8*k +: 8], "R5");
    pushPay(f ? 8'h01 : 8'h00, "R6");
    pushPay(modelErr, "R7");
    expQ.push_back(8'hC0); tagQ.push_back("R2");
  endtask

  task automatic checkOutputs();
    checks++;
    if (outValid !== modelBusy || busy !== modelBusy) begin
      errors++;
      $display("FAIL R10: valid=%0b busy=%0b expected %0b", outValid, busy, modelBusy);
    end
    if (modelBusy) begin
      checks++;
      if (outData !== expQ[0]) begin
        errors++;
        $display("FAIL %s%s: outData=%02h expected %02h",
                 prevStall ? "R9/" : "", tagQ[0], outData, expQ[0]);
      end
    end
  endtask

  // one clock: check, drive, then model the coming edge
  task automatic cycle(bit st, byte unsigned c, logic [31:0] v, bit f, byte unsigned e);
    bit rdy;
    @(negedge clk);
    cycleCount++;
    checkOutputs();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy = (readyMode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
    startPulse = st; cmdCode = c; valueWord = v; failFlag = f; errCode = e;
    outReady = rdy;
    prevStall = modelBusy && !rdy;
    if (modelBusy) begin
      if (rdy) begin
        void'(expQ.pop_front());
        void'(tagQ.pop_front());
        if (expQ.size() == 0) modelBusy = 0;
      end
    end else if (st) begin
      if (f) modelErr = e;
      buildFrame(c, v, f);
      modelBusy = 1;
    end
  endtask

  // send one reply; holdStart keeps requesting during the frame (R10)
  task automatic runFrame(byte unsigned c, logic [31:0] v, bit f, byte unsigned e, bit holdStart);
    int guard;
    cycle(1'b1, c, v, f, e);
    guard = 0;
    while (modelBusy && guard < 400) begin
      cycle(holdStart, c ^ 8'h5A, ~v, 1'b1, 8'h77);
      guard++;
    end
    if (modelBusy) begin
      checks++; errors++;
      $display("FAIL R10: frame stuck busy=%0b expected 0", busy);
    end
    cycle(1'b0, 8'h00, 32'h0, 1'b0, 8'h00);
    cycle(1'b0, 8'h00, 32'h0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b busy=%0b expected 0 0", outValid, busy);
    end
    // R1: error byte 0 after reset
    runFrame(8'h0A, 32'h12345678, 1'b0, 8'h33, 1'b0);
    // R6 R7: failure loads code
    runFrame(8'h09, 32'hCAFEF00D, 1'b1, 8'h05, 1'b0);
    // R7: success keeps code
    runFrame(8'h02, 32'h00000000, 1'b0, 8'h44, 1'b0);
    // R8: specials in command, value and error
    runFrame(8'hDB, 32'hC0DB11C0, 1'b1, 8'hC0, 1'b0);
    runFrame(8'hC0, 32'hDBDBDBDB, 1'b0, 8'h00, 1'b0);
    // R10: start held high is ignored while busy
    runFrame(8'h08, 32'hA1B2C3D4, 1'b0, 8'h00, 1'b1);
    // R9: backpressure
    readyMode = 1;
    runFrame(8'h07, 32'hC0FFEEDB, 1'b1, 8'hDB, 1'b0);
    runFrame(8'h05, 32'h01020304, 1'b0, 8'h11, 1'b1);
    runFrame(8'hDB, 32'hDBC0C0DB, 1'b1, 8'h21, 1'b0);
    runFrame(8'h03, 32'h80706050, 1'b0, 8'h00, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule